// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block sits between a processor core and its external parallel bus. The core presents one access at a time: a direction, a target space (program, data or I/O), an address and, for writes, the data. It holds the request until it sees a one-cycle acknowledge. The controller then drives the bus strobes and the space selects. It stretches each access by a programmed number of internal wait states for the addressed space. Once those are spent, it keeps stretching the access while the external device holds its ready line low.

Reads need a single strobe cycle. Writes need two: a setup cycle, then a cycle with the write enable low. A change of direction between back-to-back accesses costs one extra turnaround cycle. The first access after reset always gets at least one wait state.

An external master can ask for the bus through an active-low hold input. The controller grants it only while no access is in progress. It then reports the grant on an active-low acknowledge and drops its output enables, so that address, data and control float. When the request goes away, the controller takes the bus back.

Top module: `ebus_wait_ctrl`

## Requirements
- R1: After reset, strb_n, rd_n, we_n, every sel_n bit, rw and holda_n are high, bus_oe is high, data_oe is low and req_ack is low.
- R2: A read with zero wait states and ready high holds strb_n and rd_n low for exactly one cycle, and req_ack is high in that cycle. From the next cycle, rd_data holds the data_i value present in that cycle.
- R3: A write with zero wait states holds strb_n low for exactly two cycles. we_n is high in the first of them and low in the second. rw is low and data_oe is high with req_wdata on data_o for the whole strobe. Outside writes, rw is high and data_oe is low.
- R4: Accesses are separated by one idle cycle. A request present in the idle cycle straight after an acknowledge, whose direction differs from the access just finished, gets one more cycle with all strobes high before its strobe starts. A request of the same direction, or one after a longer gap, gets none.
- R5: The first access after reset carries at least one wait state, even when the programmed count for its space is zero.
- R6: The space index is 0 for program, 1 for data and 2 for I/O. The wait count N of space s sits in wait_cfg bits [3s+2:3s]. A read strobe lasts 1+N cycles and a write strobe 2+N cycles.
- R7: Ready is sampled in each cycle that rd_n or we_n is low, once the programmed waits are spent. Every low sample adds one cycle. A low ready during the programmed waits adds nothing.
- R8: During a strobe, exactly sel_n bit s of the addressed space is low and addr_o equals the requested address.
- R9: holda_n falls only on an edge that follows an idle cycle with hold_n low, so never during an access. While holda_n is low, bus_oe and data_oe are low and no request is acknowledged.
- R10: holda_n returns high in the cycle after hold_n is sampled high. A request pending at that point starts its strobe in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core access request, held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | SPW | Target space: 0 program, 1 data, 2 I/O |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_ack | output | 1 | High in the last cycle of an access |
| rd_data | output | DW | Data captured at the end of a read |
| wait_cfg | input | NSP*WSW | Wait-state count per space |
| ready | input | 1 | External device ready, high = ready |
| hold_n | input | 1 | External bus request, active low |
| holda_n | output | 1 | Bus grant, active low |
| addr_o | output | AW | Address to the bus |
| data_o | output | DW | Write data to the bus |
| data_i | input | DW | Read data from the bus |
| data_oe | output | 1 | Data bus driver enable |
| bus_oe | output | 1 | Address and control driver enable |
| strb_n | output | 1 | Access strobe, active low |
| rd_n | output | 1 | Read select, active low |
| we_n | output | 1 | Write enable, active low |
| rw | output | 1 | Direction: 1 read, 0 write |
| sel_n | output | NSP | Space selects, active low |

## Verification
The hardest case to reach is a bus request that arrives while an access is stretched by both programmed waits and a low ready, with a core request already pending when the grant is released. The bench starts a read with several waits and raises the hold request from a parallel thread partway through. It presents a new request during the grant and then releases hold. It checks the exact cycles at which the grant falls and rises and at which the pending strobe starts. Turnaround cycles are reached by issuing back-to-back requests in the idle cycle after an acknowledge, with random direction changes.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_TURN    = 3'd1,
        ST_READ    = 3'd2,
        ST_WSETUP  = 3'd3,
        ST_WSTROBE = 3'd4
    } ebus_state_e;

endpackage

// File: rtl/ebus_wait_timer.sv
module ebus_wait_timer #(
    parameter int W = 3
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R6: a non-zero load must hold off expiry for at least one cycle
    p_load_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/ebus_hold_arb.sv
module ebus_hold_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_n,
    input  logic seq_idle,
    output logic granted
);

    logic granted_d, granted_q;

    always_comb begin
        if (granted_q) granted_d = !hold_n;
        else           granted_d = !hold_n && seq_idle;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) granted_q <= 1'b0;
        else        granted_q <= granted_d;
    end

    assign granted = granted_q;

    p_grant_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(granted_q) |-> $past(seq_idle && !hold_n));

    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (granted_q && hold_n) |=> !granted_q);

endmodule

// File: rtl/ebus_pin_drv.sv
module ebus_pin_drv
    import ebus_pkg::*;
#(
    parameter int NSP = 3,
    parameter int SPW = 2
)(
    input  ebus_state_e    state,
    input  logic [SPW-1:0] space,
    output logic           strb_n,
    output logic           rd_n,
    output logic           we_n,
    output logic           rw,
    output logic           data_oe,
    output logic [NSP-1:0] sel_n
);

    logic in_strobe;
    logic in_write;

    assign in_write  = (state == ST_WSETUP) || (state == ST_WSTROBE);
    assign in_strobe = (state == ST_READ) || in_write;

    assign strb_n  = !in_strobe;
    assign rd_n    = (state != ST_READ);
    assign we_n    = (state != ST_WSTROBE);
    assign rw      = !in_write;
    assign data_oe = in_write;

    for (genvar i = 0; i < NSP; i++) begin : g_sel
        assign sel_n[i] = !(in_strobe && (space == SPW'(i)));
    end

endmodule

// File: rtl/ebus_wait_ctrl.sv
module ebus_wait_ctrl
    import ebus_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int NSP = 3,
    parameter int WSW = 3,
    localparam int SPW = (NSP > 1) ? $clog2(NSP) : 1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [SPW-1:0]     req_space,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               req_ack,
    output logic [DW-1:0]      rd_data,
    input  logic [NSP*WSW-1:0] wait_cfg,
    input  logic               ready,
    input  logic               hold_n,
    output logic               holda_n,
    output logic [AW-1:0]      addr_o,
    output logic [DW-1:0]      data_o,
    input  logic [DW-1:0]      data_i,
    output logic               data_oe,
    output logic               bus_oe,
    output logic               strb_n,
    output logic               rd_n,
    output logic               we_n,
    output logic               rw,
    output logic [NSP-1:0]     sel_n
);

    typedef struct packed {
        ebus_state_e    state;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [DW-1:0]  rdata;
        logic [SPW-1:0] space;
        logic           wr;
        logic           first;
        logic           adj;
        logic           last_rd;
    } seq_t;

    seq_t seq_d, seq_q;

    logic           granted;
    logic           tmr_load;
    logic           tmr_expired;
    logic [SPW-1:0] tmr_sel;
    logic [WSW-1:0] cfg_pick;
    logic [WSW-1:0] load_val;

    // wait count of the selected space, raised to one on the first access
    always_comb begin
        cfg_pick = '0;
        for (int i = 0; i < NSP; i++) begin
            if (tmr_sel == SPW'(i)) cfg_pick = wait_cfg[i*WSW +: WSW];
        end
        load_val = (seq_q.first && cfg_pick == '0) ? WSW'(1) : cfg_pick;
    end

    always_comb begin
        seq_d    = seq_q;
        seq_d.adj = 1'b0;
        tmr_load = 1'b0;
        tmr_sel  = seq_q.space;
        req_ack  = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (req_valid && hold_n && !granted) begin
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    seq_d.space = req_space;
                    seq_d.wr    = req_write;
                    if (seq_q.adj && (seq_q.last_rd == req_write)) begin
                        seq_d.state = ST_TURN;
                    end else if (req_write) begin
                        seq_d.state = ST_WSETUP;
                    end else begin
                        seq_d.state = ST_READ;
                        tmr_load    = 1'b1;
                        tmr_sel     = req_space;
                    end
                end
            end
            ST_TURN: begin
                if (seq_q.wr) begin
                    seq_d.state = ST_WSETUP;
                end else begin
                    seq_d.state = ST_READ;
                    tmr_load    = 1'b1;
                end
            end
            ST_WSETUP: begin
                seq_d.state = ST_WSTROBE;
                tmr_load    = 1'b1;
            end
            ST_READ, ST_WSTROBE: begin
                if (tmr_expired && ready) begin
                    req_ack       = 1'b1;
                    seq_d.state   = ST_IDLE;
                    seq_d.adj     = 1'b1;
                    seq_d.last_rd = !seq_q.wr;
                    seq_d.first   = 1'b0;
                    if (!seq_q.wr) seq_d.rdata = data_i;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, addr: '0, wdata: '0, rdata: '0,
                       space: '0, wr: 1'b0, first: 1'b1, adj: 1'b0,
                       last_rd: 1'b1};
        end else begin
            seq_q <= seq_d;
        end
    end

    ebus_wait_timer #(.W(WSW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (load_val),
        .expired  (tmr_expired)
    );

    ebus_hold_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_n   (hold_n),
        .seq_idle (seq_q.state == ST_IDLE),
        .granted  (granted)
    );

    ebus_pin_drv #(.NSP(NSP), .SPW(SPW)) u_pins (
        .state   (seq_q.state),
        .space   (seq_q.space),
        .strb_n  (strb_n),
        .rd_n    (rd_n),
        .we_n    (we_n),
        .rw      (rw),
        .data_oe (data_oe),
        .sel_n   (sel_n)
    );

    assign holda_n = !granted;
    assign bus_oe  = !granted;
    assign addr_o  = seq_q.addr;
    assign data_o  = seq_q.wdata;
    assign rd_data = seq_q.rdata;

    // R5: the first access may not finish in the first cycle of its strobe phase
    p_first_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack && seq_q.first) |-> (seq_q.state == $past(seq_q.state)));

    p_we_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(!strb_n));

    p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !rw);

    p_grant_no_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !holda_n |-> (seq_q.state == ST_IDLE && !req_ack));

    p_ack_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (ready && !strb_n));

    p_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n));

endmodule

// File: tb/tb_ebus_wait_ctrl.sv
module tb_ebus_wait_ctrl;

    localparam int AW = 16, DW = 16, NSP = 3, WSW = 3, SPW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [SPW-1:0] req_space = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, data_i = '0;
    logic [NSP*WSW-1:0] wait_cfg = '0;
    logic ready = 1'b1, hold_n = 1'b1;
    logic req_ack, holda_n, data_oe, bus_oe, strb_n, rd_n, we_n, rw;
    logic [DW-1:0] rd_data, data_o;
    logic [AW-1:0] addr_o;
    logic [NSP-1:0] sel_n;

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    bit last_wr = 1'b0;

    always #4 clk = ~clk;

    ebus_wait_ctrl #(.AW(AW), .DW(DW), .NSP(NSP), .WSW(WSW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .rd_data(rd_data), .wait_cfg(wait_cfg), .ready(ready),
        .hold_n(hold_n), .holda_n(holda_n), .addr_o(addr_o), .data_o(data_o),
        .data_i(data_i), .data_oe(data_oe), .bus_oe(bus_oe), .strb_n(strb_n),
        .rd_n(rd_n), .we_n(we_n), .rw(rw), .sel_n(sel_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cfg_of(input logic [NSP*WSW-1:0] cfg, input int sp);
        return int'((cfg >> (sp*WSW)) & 9'h7);
    endfunction

    function automatic int exp_len(input bit wr, input int n, input int r, input bit first);
        int neff = (first && n == 0) ? 1 : n;
        return (wr ? 2 : 1) + ((neff > r) ? neff : r);
    endfunction

    // one access: returns strobe length, strobe-high cycles before it,
    // pin correctness and read data correctness
    task automatic access(input bit wr, input int sp, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input int r,
                          output int len, output int pre, output bit sig_ok,
                          output bit rd_ok);
        logic [DW-1:0] rv;
        int idx = 0;
        bit done = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_space = SPW'(sp);
        req_addr = a; req_wdata = wd; ready = 1'b1;
        rv = DW'($urandom); data_i = rv;
        len = 0; pre = 0; sig_ok = 1'b1; rd_ok = 1'b1;
        while (!done) begin
            @(negedge clk);
            if (strb_n) begin
                if (len == 0) pre++;
            end else begin
                len++;
                if (addr_o !== a || sel_n !== ~(NSP'(1) << sp)) sig_ok = 1'b0;
                if (rw !== !wr || !holda_n || !bus_oe) sig_ok = 1'b0;
                if (wr && (!data_oe || data_o !== wd)) sig_ok = 1'b0;
                if (wr && (we_n !== (len == 1))) sig_ok = 1'b0;
                if (!wr && (data_oe || !we_n || rd_n)) sig_ok = 1'b0;
            end
            if (!rd_n || !we_n) begin
                ready = (idx >= r);
                idx++;
            end else begin
                ready = 1'b1;
            end
            #1;
            if (req_ack) done = 1'b1;
        end
        req_valid = 1'b0; ready = 1'b1;
        @(posedge clk); #1;
        if (!wr) rd_ok = (rd_data === rv);
        last_wr = wr;
    endtask

    task automatic run(input string tag, input bit wr, input int sp, input int r,
                       input bit adj, input bit have_prev, input bit first);
        int len, pre, n;
        bit sok, rok, pw;
        logic [AW-1:0] a;
        logic [DW-1:0] wd;
        pw = last_wr;
        a = AW'($urandom); wd = DW'($urandom);
        if (!adj) repeat (2) @(negedge clk);
        n = cfg_of(wait_cfg, sp);
        access(wr, sp, a, wd, r, len, pre, sok, rok);
        check(len == exp_len(wr, n, r, first), {tag, " R6 R7 strobe length"}, len,
              exp_len(wr, n, r, first));
        check(pre == ((adj && have_prev && pw != wr) ? 1 : 0), {tag, " R4 turnaround"},
              pre, (adj && have_prev && pw != wr) ? 1 : 0);
        check(sok, {tag, " R3 R8 pin levels during strobe"}, int'(sok), 1);
        if (!wr) check(rok, {tag, " R2 read data"}, int'(rok), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int len, pre;
        bit sok, rok;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(strb_n && rd_n && we_n && rw && (&sel_n) && holda_n && bus_oe
              && !data_oe && !req_ack, "R1 reset levels", 0, 1);

        // R5 first access gets a wait even with a zero count
        wait_cfg = '0;
        run("first", 1'b0, 1, 0, 1'b0, 1'b0, 1'b1);
        // R2 zero-wait read, R3 zero-wait write
        run("read0", 1'b0, 0, 0, 1'b0, 1'b1, 1'b0);
        run("write0", 1'b1, 1, 0, 1'b0, 1'b1, 1'b0);
        // R4 adjacency cases
        run("rd_gap", 1'b0, 2, 0, 1'b0, 1'b1, 1'b0);
        run("rd_to_wr", 1'b1, 2, 0, 1'b1, 1'b1, 1'b0);
        run("wr_to_rd", 1'b0, 0, 0, 1'b1, 1'b1, 1'b0);
        run("rd_to_rd", 1'b0, 1, 0, 1'b1, 1'b1, 1'b0);
        run("wr_gap", 1'b1, 0, 0, 1'b0, 1'b1, 1'b0);
        run("wr_to_wr", 1'b1, 1, 0, 1'b1, 1'b1, 1'b0);
        // R6 per-space counts: program 2, data 5, io 7
        wait_cfg = {3'd7, 3'd5, 3'd2};
        run("prog_w2", 1'b0, 0, 0, 1'b0, 1'b1, 1'b0);
        run("data_w5", 1'b0, 1, 0, 1'b0, 1'b1, 1'b0);
        run("io_w7", 1'b1, 2, 0, 1'b0, 1'b1, 1'b0);
        // R7 ready extends past the waits, and is ignored inside them
        wait_cfg = {3'd0, 3'd1, 3'd6};
        run("rdy_rd", 1'b0, 1, 4, 1'b0, 1'b1, 1'b0);
        run("rdy_wr", 1'b1, 2, 3, 1'b0, 1'b1, 1'b0);
        run("rdy_inside", 1'b0, 0, 3, 1'b0, 1'b1, 1'b0);

        // R9 / R10 hold raised in the middle of a stretched read
        wait_cfg = {3'd0, 3'd3, 3'd0};
        repeat (2) @(negedge clk);
        fork
            access(1'b0, 1, 16'h1234, 16'h0, 0, len, pre, sok, rok);
            begin
                repeat (2) @(negedge clk);
                hold_n = 1'b0;
            end
        join
        check(len == 4 && sok, "R9 access finishes under pending hold", len, 4);
        @(negedge clk);
        check(holda_n == 1'b1, "R9 no grant in the idle cycle", int'(holda_n), 1);
        @(negedge clk);
        check(!holda_n && !bus_oe && !data_oe, "R9 grant floats bus", int'(bus_oe), 0);
        req_valid = 1'b1; req_write = 1'b0; req_space = 2'd0; req_addr = 16'h00AA;
        repeat (3) begin
            @(negedge clk); #1;
            check(!req_ack && !holda_n && strb_n, "R9 no access while granted",
                  int'(req_ack), 0);
        end
        hold_n = 1'b1;
        @(negedge clk);
        check(holda_n && bus_oe && strb_n, "R10 grant drops one cycle after release",
              int'(holda_n), 1);
        @(negedge clk); #1;
        check(!strb_n && req_ack && !sel_n[0], "R10 pending request starts",
              int'(strb_n), 0);
        req_valid = 1'b0;
        @(posedge clk); #1;
        last_wr = 1'b0;

        // random mix
        for (int k = 0; k < 80; k++) begin
            wait_cfg = NSP*WSW'($urandom);
            run("rand", 1'($urandom % 2), int'($urandom % 3), int'($urandom % 5),
                1'($urandom % 2), 1'b1, 1'b0);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule